// File: doc/BRIEF.md
# I2C Master Auto-Transfer Sequencer

This block is the control half of an I2C master. Software loads a target address and a transfer word, giving the byte count, the direction and whether to finish with STOP, then sets a run bit. From there the sequencer runs the whole transfer with no further help. It issues START and the address byte, then moves data bytes between the bus and two small FIFOs. It ends with STOP, or keeps the bus so that the next transfer opens with a repeated START.

Bit-level SCL/SDA timing belongs to a separate serializer. The sequencer sends it one command at a time (START, STOP, write a byte, read a byte) and waits for that command's completion pulse. The completion pulse returns the received byte, the acknowledge bit it sampled and any arbitration loss. Each outcome goes into its own sticky status bit, and every ending raises one completion interrupt. Software clears the interrupt by writing a one to it.

Top module: `i2c_auto_master`

## Requirements
- R1: A write of register 1 with bit 31 set starts a transfer, and the busy bit (status register 3, bit 17) reads 1 from the next cycle. This needs a non-zero count in bits [15:0], control bits 0 and 3 both set, and control bit 7 for a write (bit 16 = 0) or control bit 6 for a read (bit 16 = 1). If any of these is missing the run bit is ignored.
- R2: Every transfer issues START first, then writes the address byte. The address byte is {address register bits [16:10], direction}, with 1 meaning read.
- R3: A write sends the transmit FIFO bytes (pushed through register 6) in push order. While bytes remain and the FIFO is empty, no command is issued.
- R4: A read pushes each received byte into the receive FIFO, which software pops by reading register 7. NACK is requested on the last byte only. While the receive FIFO is full, no read command is issued.
- R5: With bit 17 of the transfer word set, STOP follows the last byte. Without it the transfer ends with no STOP, and the next transfer begins with a START (a repeated start).
- R6: A transfer that completes cleanly sets status bit 0 and interrupt bit 9 (register 4). The `irq` output follows bit 9.
- R7: A NACK to the address byte sets status bit 3, and a NACK to a data byte sets status bit 2. In both cases the sequencer issues STOP at once and leaves status bit 0 clear.
- R8: Arbitration loss sets status bit 1 and ends the transfer without STOP.
- R9: When a command goes TOUT_CYC cycles without a completion pulse, the sequencer sets status bit 4, ends the transfer without STOP and raises the interrupt.
- R10: The busy bit stays set until the final STOP completes. When no STOP is issued, it stays set until the final byte completes.
- R11: Writing 1 to register 4 bit 9 clears the interrupt. Status bits 0 to 4 stay set until the next accepted run clears them.
- R12: Register 5 reports RX empty at bit 24, RX full at bit 23, RX level at [22:16], TX empty at bit 8, TX full at bit 7 and TX level at [6:0]. Reading register 7 while the receive FIFO is empty returns 0.
- R13: While control bit 31 is set, the sequencer returns to idle, both FIFOs empty, and status and interrupt clear. After the bit is cleared, a new transfer runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at register 7) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| bit_cmd_valid | output | 1 | Command pending to the bit serializer |
| bit_cmd | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| bit_tx_byte | output | 8 | Byte to write |
| bit_tx_nack | output | 1 | Answer the byte being read with NACK |
| bit_done | input | 1 | Completion pulse for the pending command |
| bit_rx_byte | input | 8 | Byte read, valid with bit_done |
| bit_ack_n | input | 1 | Target did not acknowledge, valid with bit_done |
| bit_arb_lost | input | 1 | Arbitration lost, valid with bit_done |

## Verification
The hardest states to reach from the ports are the two stalls and the stuck serializer. The bench plays the serializer as a responder model that can be set to hang. To stall a write, it starts the transfer with fewer bytes in the transmit FIFO than the count asks for. To stall a read, it asks for more bytes than the receive FIFO holds and pops nothing. For each stall it confirms that no command goes out while stalled, and that the transfer then finishes in order once the FIFO is served. The same model injects NACKs on chosen bytes and arbitration loss on a chosen command, so each error path is checked against the exact command log.

// File: rtl/i2c_auto_master.sv
module i2c_auto_master #(
  parameter int DEPTH    = 8,
  parameter int LEN_W    = 16,
  parameter int TOUT_CYC = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        bit_cmd_valid,
  output logic [1:0]  bit_cmd,
  output logic [7:0]  bit_tx_byte,
  output logic        bit_tx_nack,
  input  logic        bit_done,
  input  logic [7:0]  bit_rx_byte,
  input  logic        bit_ack_n,
  input  logic        bit_arb_lost
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TOUT_CYC + 1);
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WR = 2'd2, C_RD = 2'd3;
  localparam logic [2:0] A_CTRL = 3'd0, A_XFER = 3'd1, A_TADR = 3'd2, A_STAT = 3'd3,
                         A_INT = 3'd4, A_FIFO = 3'd5, A_TXD = 3'd6, A_RXD = 3'd7;
  localparam logic [31:0] CTRL_MASK = 32'h8000_00C9;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_WR, S_RD, S_STOP} st_t;
  st_t st;

  logic [31:0] ctrl_q, xfer_q, tadr_q;
  logic [4:0]  xst_q;
  logic [4:1]  err_q;
  logic        int_q, dir_q, stop_q;
  logic [7:0]  abyte_q;
  logic [LEN_W-1:0] rem_q;
  logic [TW-1:0] tout_q;

  logic [7:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire sw_rst   = ctrl_q[31];
  wire busy     = (st != S_IDLE);
  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == CW'(DEPTH));

  wire go = reg_wr && reg_addr == A_XFER && reg_wdata[31] && !busy && !sw_rst &&
            reg_wdata[LEN_W-1:0] != '0 && ctrl_q[0] && ctrl_q[3] &&
            (reg_wdata[16] ? ctrl_q[6] : ctrl_q[7]);

  wire tx_push = reg_wr && reg_addr == A_TXD && !tx_full && !sw_rst;
  wire rx_pop  = reg_rd && reg_addr == A_RXD && !rx_empty && !sw_rst;
  wire acc     = bit_cmd_valid && bit_done;
  wire tx_pop  = acc && st == S_WR;
  wire rx_push = acc && st == S_RD && !bit_arb_lost;
  wire stuck   = bit_cmd_valid && !bit_done && tout_q == TW'(TOUT_CYC - 1);

  always_comb begin
    bit_cmd_valid = 1'b0;
    bit_cmd       = C_START;
    unique case (st)
      S_START: bit_cmd_valid = 1'b1;
      S_ADDR:  begin bit_cmd_valid = 1'b1;      bit_cmd = C_WR; end
      S_WR:    begin bit_cmd_valid = !tx_empty; bit_cmd = C_WR; end
      S_RD:    begin bit_cmd_valid = !rx_full;  bit_cmd = C_RD; end
      S_STOP:  begin bit_cmd_valid = 1'b1;      bit_cmd = C_STOP; end
      default: ;
    endcase
  end

  assign bit_tx_byte = (st == S_ADDR) ? abyte_q : txm[tx_rp];
  assign bit_tx_nack = (st == S_RD) && rem_q == LEN_W'(1);
  assign irq = int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; xfer_q <= '0; tadr_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
      if (reg_wr && reg_addr == A_XFER) xfer_q <= {1'b0, reg_wdata[30:0]};
      if (reg_wr && reg_addr == A_TADR) tadr_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; xst_q <= '0; err_q <= '0; int_q <= 1'b0;
      dir_q <= 1'b0; stop_q <= 1'b0; abyte_q <= '0; rem_q <= '0; tout_q <= '0;
    end else if (sw_rst) begin
      st <= S_IDLE; xst_q <= '0; err_q <= '0; int_q <= 1'b0; rem_q <= '0; tout_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_INT && reg_wdata[9]) int_q <= 1'b0;
      if (go) begin
        st      <= S_START;
        rem_q   <= reg_wdata[LEN_W-1:0];
        dir_q   <= reg_wdata[16];
        stop_q  <= reg_wdata[17];
        abyte_q <= {tadr_q[16:10], reg_wdata[16]};
        xst_q   <= '0;
        err_q   <= '0;
        tout_q  <= '0;
      end else if (busy) begin
        tout_q <= (bit_cmd_valid && !bit_done) ? tout_q + TW'(1) : '0;
        if (stuck) begin
          st <= S_IDLE; xst_q <= {1'b1, err_q[3:1], 1'b0}; int_q <= 1'b1;
        end else if (acc) begin
          if (bit_arb_lost && st != S_STOP) begin
            st <= S_IDLE; xst_q <= 5'b00010; int_q <= 1'b1;
          end else begin
            unique case (st)
              S_START: st <= S_ADDR;
              S_ADDR: begin
                if (bit_ack_n) begin err_q[3] <= 1'b1; st <= S_STOP; end
                else st <= dir_q ? S_RD : S_WR;
              end
              S_WR, S_RD: begin
                if (st == S_WR && bit_ack_n) begin
                  err_q[2] <= 1'b1; st <= S_STOP;
                end else begin
                  rem_q <= rem_q - LEN_W'(1);
                  if (rem_q == LEN_W'(1)) begin
                    if (stop_q) st <= S_STOP;
                    else begin st <= S_IDLE; xst_q <= 5'b00001; int_q <= 1'b1; end
                  end
                end
              end
              S_STOP: begin
                st <= S_IDLE; int_q <= 1'b1;
                xst_q <= {err_q, err_q == '0};
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rxm[rx_wp] <= bit_rx_byte;
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (sw_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: reg_rdata = ctrl_q;
      A_XFER: reg_rdata = xfer_q;
      A_TADR: reg_rdata = tadr_q;
      A_STAT: begin reg_rdata[17] = busy; reg_rdata[4:0] = xst_q; end
      A_INT:  reg_rdata[9] = int_q;
      A_FIFO: begin
        reg_rdata[24]    = rx_empty;
        reg_rdata[23]    = rx_full;
        reg_rdata[22:16] = 7'(rx_cnt);
        reg_rdata[8]     = tx_empty;
        reg_rdata[7]     = tx_full;
        reg_rdata[6:0]   = 7'(tx_cnt);
      end
      A_RXD:  reg_rdata = rx_empty ? '0 : {24'b0, rxm[rx_rp]};
      default: reg_rdata = '0;
    endcase
  end

  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bit_cmd_valid && bit_cmd == C_START);
  a_r3_no_write_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && bit_cmd_valid) |-> !tx_empty);
  a_r4_no_read_into_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full || rx_pop);
  a_r6_int_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(sw_rst)) |-> int_q);
  a_r7_ok_excludes_error: assert property (@(posedge clk) disable iff (!rst_n)
    xst_q[0] |-> xst_q[4:1] == '0);
  a_r10_cmd_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cmd_valid |-> busy);
  a_r12_fifo_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));
  a_r13_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_rst) |-> !busy && tx_empty && rx_empty);
endmodule

// File: tb/tb_i2c_auto_master.sv
module tb_i2c_auto_master;
  localparam int DEPTH = 8;
  localparam int TOUT = 200;
  localparam logic [31:0] EN_ALL = 32'hC9;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, bit_cmd_valid, bit_tx_nack;
  logic [1:0] bit_cmd;
  logic [7:0] bit_tx_byte;
  logic bit_done = 0, bit_ack_n = 0, bit_arb_lost = 0;
  logic [7:0] bit_rx_byte = 0;

  i2c_auto_master #(.DEPTH(DEPTH), .LEN_W(16), .TOUT_CYC(TOUT)) dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int nlog = 0;
  logic [1:0] lc [64];
  logic [7:0] lb [64];
  logic       ln [64];
  bit hang = 0, nack_addr = 0;
  int nack_data_at = -1, arb_at = -1;

  initial begin
    int lat = 0, wr_idx = 0, rd_idx = 0;
    forever begin
      @(negedge clk);
      if (bit_done) begin
        bit_done = 0; bit_ack_n = 0; bit_arb_lost = 0; lat = 0;
      end else if (rst_n && bit_cmd_valid && !hang) begin
        lat++;
        if (lat >= 2) begin
          if (nlog < 64) begin
            lc[nlog] = bit_cmd; lb[nlog] = bit_tx_byte; ln[nlog] = bit_tx_nack;
          end
          bit_arb_lost = (arb_at == nlog);
          nlog++;
          if (bit_cmd == 2'd0) begin wr_idx = 0; rd_idx = 0; end
          if (bit_cmd == 2'd2) begin
            bit_ack_n = (wr_idx == 0) ? nack_addr : (wr_idx - 1 == nack_data_at);
            wr_idx++;
          end
          if (bit_cmd == 2'd3) begin bit_rx_byte = 8'hA0 + 8'(rd_idx); rd_idx++; end
          bit_done = 1;
        end
      end else lat = 0;
    end
  end

  initial begin
    #1600000;
    $display("FAIL watchdog: run hung");
    fails++; tests++;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: actual %h expected %h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = pop; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd3, 0, s);
      if (!s[17]) return;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_log(input int idx, input logic [1:0] c, input logic [7:0] b, input string req);
    chk(idx < nlog && lc[idx] == c && (c != 2'd2 || lb[idx] == b), req,
        {22'b0, lc[idx], lb[idx]}, {22'b0, c, b});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd3, 0, d); chk(d == 0, "R10 reset status", d, 0);
    rd(3'd5, 0, d); chk(d == 32'h0100_0100, "R12 reset fifo status", d, 32'h0100_0100);
    chk(irq == 0 && bit_cmd_valid == 0, "R6 reset irq", {30'b0, irq, bit_cmd_valid}, 0);
  endtask

  task automatic t_write_stop();
    logic [31:0] d;
    nlog = 0;
    wr(3'd2, 32'h50 << 10);
    wr(3'd6, 8'h11); wr(3'd6, 8'h22); wr(3'd6, 8'h33);
    rd(3'd5, 0, d); chk(d[6:0] == 3 && d[8] == 0, "R12 tx level", d, 32'h3);
    wr(3'd1, 32'h8002_0003);
    rd(3'd3, 0, d); chk(d[17] == 1, "R1 busy after run", d, 32'h2_0000);
    wait_idle();
    chk(nlog == 6, "R5 write log length", nlog, 6);
    chk_log(0, 2'd0, 0, "R2 start");
    chk_log(1, 2'd2, 8'hA0, "R2 address byte");
    chk_log(2, 2'd2, 8'h11, "R3 byte0");
    chk_log(3, 2'd2, 8'h22, "R3 byte1");
    chk_log(4, 2'd2, 8'h33, "R3 byte2");
    chk_log(5, 2'd1, 0, "R5 stop");
    rd(3'd3, 0, d); chk(d == 1, "R6 success status", d, 1);
    rd(3'd4, 0, d); chk(d == 32'h200 && irq, "R6 interrupt", d, 32'h200);
    wr(3'd4, 32'h200);
    rd(3'd4, 0, d); chk(d == 0 && !irq, "R11 interrupt clear", d, 0);
    rd(3'd3, 0, d); chk(d == 1, "R11 status sticky", d, 1);
  endtask

  task automatic t_read_stop();
    logic [31:0] d;
    nlog = 0;
    wr(3'd2, 32'h2B << 10);
    wr(3'd1, 32'h8003_0003);
    wait_idle();
    chk(nlog == 6, "R4 read log length", nlog, 6);
    chk_log(1, 2'd2, 8'h57, "R2 read address byte");
    for (int i = 0; i < 3; i++)
      chk(lc[2+i] == 2'd3 && ln[2+i] == (i == 2), "R4 nack on last only", {31'b0, ln[2+i]}, (i == 2));
    chk_log(5, 2'd1, 0, "R5 stop after read");
    for (int i = 0; i < 3; i++) begin
      rd(3'd7, 1, d); chk(d == 32'hA0 + i, "R4 read data", d, 32'hA0 + i);
    end
    rd(3'd7, 1, d); chk(d == 0, "R12 empty pop", d, 0);
  endtask

  task automatic t_repeated_start();
    logic [31:0] d;
    nlog = 0;
    wr(3'd6, 8'h05);
    wr(3'd1, 32'h8000_0001);
    wait_idle();
    chk(nlog == 3, "R5 no stop without request", nlog, 3);
    rd(3'd3, 0, d); chk(d == 1, "R10 busy clear, no stop", d, 1);
    wr(3'd1, 32'h8003_0001);
    wait_idle();
    chk_log(3, 2'd0, 0, "R5 repeated start");
    chk(nlog == 7, "R5 probe read length", nlog, 7);
    rd(3'd3, 0, d); chk(d == 1, "R4 probe success", d, 1);
    rd(3'd7, 1, d); chk(d == 32'hA0, "R4 probe byte", d, 32'hA0);
  endtask

  task automatic t_tx_stall();
    logic [31:0] d;
    nlog = 0;
    wr(3'd6, 8'h71);
    wr(3'd1, 32'h8002_0003);
    idle(40);
    chk(nlog == 3 && !bit_cmd_valid, "R3 stall on empty tx", nlog, 3);
    rd(3'd3, 0, d); chk(d[17], "R10 busy while stalled", d, 32'h2_0000);
    wr(3'd6, 8'h72); wr(3'd6, 8'h73);
    wait_idle();
    chk_log(3, 2'd2, 8'h72, "R3 after stall 1");
    chk_log(4, 2'd2, 8'h73, "R3 after stall 2");
    chk_log(5, 2'd1, 0, "R5 stop after stall");
  endtask

  task automatic t_rx_stall();
    logic [31:0] d;
    nlog = 0;
    wr(3'd1, 32'h8003_0000 | (DEPTH + 2));
    idle(80);
    rd(3'd5, 0, d);
    chk(d[23] && d[22:16] == DEPTH, "R12 rx full flag", d, 32'h0080_0000 | (DEPTH << 16));
    chk(nlog == 2 + DEPTH, "R4 stall on full rx", nlog, 2 + DEPTH);
    for (int i = 0; i < DEPTH + 2; i++) begin
      for (int k = 0; k < 20; k++) begin
        rd(3'd5, 0, d);
        if (!d[24]) break;
      end
      rd(3'd7, 1, d); chk(d == 32'hA0 + i, "R4 stalled read data", d, 32'hA0 + i);
    end
    wait_idle();
    chk(ln[1 + DEPTH + 2] && !ln[1 + DEPTH + 1], "R4 nack last of long read", {31'b0, ln[1+DEPTH+2]}, 1);
  endtask

  task automatic t_nack();
    logic [31:0] d;
    nlog = 0; nack_addr = 1;
    wr(3'd6, 8'h01);
    wr(3'd1, 32'h8002_0001);
    wait_idle(); nack_addr = 0;
    chk(nlog == 3 && lc[2] == 2'd1, "R7 stop after address nack", nlog, 3);
    rd(3'd3, 0, d); chk(d == 32'h8, "R7 no device bit", d, 32'h8);
    wr(3'd4, 32'h200);
    nlog = 0; nack_data_at = 0;
    wr(3'd6, 8'h02);
    wr(3'd1, 32'h8002_0002);
    wait_idle(); nack_data_at = -1;
    chk(nlog == 4 && lc[3] == 2'd1, "R7 stop after data nack", nlog, 4);
    rd(3'd3, 0, d); chk(d == 32'h4, "R7 no ack bit", d, 32'h4);
    chk(irq, "R7 interrupt on error", {31'b0, irq}, 1);
    wr(3'd4, 32'h200);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    nlog = 0; arb_at = 1;
    wr(3'd1, 32'h8002_0001);
    wait_idle(); arb_at = -1;
    chk(nlog == 2, "R8 no stop after arbitration loss", nlog, 2);
    rd(3'd3, 0, d); chk(d == 32'h2, "R8 abort bit", d, 32'h2);
    wr(3'd4, 32'h200);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(3'd4, 32'h200);
    nlog = 0; hang = 1;
    wr(3'd1, 32'h8002_0001);
    idle(TOUT - 30);
    rd(3'd3, 0, d); chk(d[17], "R9 still waiting before limit", d, 32'h2_0000);
    idle(50);
    rd(3'd3, 0, d); chk(d == 32'h10, "R9 timeout bit", d, 32'h10);
    chk(irq && nlog == 0, "R9 interrupt, no stop", nlog, 0);
    hang = 0;
    wr(3'd4, 32'h200);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    nlog = 0;
    wr(3'd1, 32'h8002_0000);
    idle(10);
    rd(3'd3, 0, d); chk(!d[17] && nlog == 0, "R1 zero length ignored", d, 0);
    wr(3'd0, 32'h89);
    wr(3'd1, 32'h8003_0001);
    idle(10);
    rd(3'd3, 0, d); chk(!d[17] && nlog == 0, "R1 read without rx enable ignored", d, 0);
    wr(3'd0, EN_ALL);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    nlog = 0;
    wr(3'd1, 32'h8002_0002);
    idle(20);
    wr(3'd0, EN_ALL | 32'h8000_0000);
    idle(3);
    rd(3'd3, 0, d); chk(d == 0, "R13 idle and cleared", d, 0);
    rd(3'd5, 0, d); chk(d == 32'h0100_0100, "R13 fifos empty", d, 32'h0100_0100);
    wr(3'd0, EN_ALL);
    nlog = 0;
    wr(3'd6, 8'h9C);
    wr(3'd1, 32'h8002_0001);
    wait_idle();
    rd(3'd3, 0, d); chk(d == 1, "R13 runs after reset", d, 1);
    chk_log(2, 2'd2, 8'h9C, "R13 byte after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    wr(3'd0, EN_ALL);
    t_write_stop();
    t_read_stop();
    t_repeated_start();
    t_tx_stall();
    t_rx_stall();
    t_nack();
    t_arb();
    t_timeout();
    t_ignored();
    t_soft_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule